// File: doc/BRIEF.md
# Greedy Cache Configuration Search Controller

This controller tunes a configurable cache while a program runs. Software raises an enable line. The controller then walks four cache parameters one at a time, in a fixed order: total size, line size, associativity and way prediction. For each trial it places a candidate configuration on its 7-bit configuration output, which drives the cache directly. It then asks an external energy datapath to measure that candidate. The datapath answers with a done strobe and a flag. The flag says whether the candidate's energy is lower than the best energy seen so far in this search.

Each parameter only ever moves upward from its current value. A search therefore never shrinks the cache or its associativity, and no flush is ever needed. A parameter keeps stepping while energy keeps falling. At the first trial that does not lower energy, the controller returns the output to the best configuration and moves on to the next parameter. A search that starts from the smallest configuration evaluates at most eight configurations: one baseline and at most seven trials. The energy arithmetic, the counters and the cache array belong to other blocks.

Top module: `cache_tune_ctrl`

## Requirements
- R1: After reset, `cacheCfg` is 0 (2 KB, 16-byte lines, direct-mapped, way prediction off), `busy` is 0 and `evalReq` is 0.
- R2: The fields of `cacheCfg` are laid out as follows.
  - Bits [6:5] hold the size: 00 = 2 KB, 01 = 4 KB, 10 = 8 KB.
  - Bits [4:3] hold the line size: 00 = 16 B, 01 = 32 B, 10 = 64 B.
  - Bits [2:1] hold the associativity: 00 = 1 way, 01 = 2 ways, 10 = 4 ways.
  - Bit [0] is 1 when way prediction is on.
  - The code 11 is never produced in any 2-bit field.
- R3: A search starts when `tuneEn` is high while the controller is idle. Its first request evaluates the configuration currently on `cacheCfg` as the baseline. The `evalLower` flag returned for the baseline is ignored.
- R4: After the baseline, the parameters are tuned in this order: size, line size, associativity, way prediction. Each trial raises only the field being tuned, by one code above the best value. `evalReq` stays high, and `cacheCfg` stays stable, until `evalDone` arrives.
- R5: If `evalDone` arrives with `evalLower` = 1, the candidate becomes the best configuration and the same parameter steps again. If `evalLower` = 0, `cacheCfg` returns to the best configuration and the next parameter begins.
- R6: Size and line size stop at code 10 and way prediction stops at 1. The associativity code never exceeds the size code, so 2 KB allows only 1 way and 4 KB allows at most 2 ways. No trial is requested beyond these limits.
- R7: `busy` is high from the start of a search until the last parameter has been decided. Afterwards `cacheCfg` holds the final best configuration. No new search starts while `tuneEn` stays high; a new search needs `tuneEn` to go low first.
- R8: If `tuneEn` falls during a search, the controller is idle on the next cycle, with `busy` and `evalReq` low and `cacheCfg` equal to the best configuration found so far.
- R9: An `evalDone` that arrives while `evalReq` is low has no effect.
- R10: A new search starts from the current configuration, so the size field never drops below its value from before the search, except when a rejected trial is reverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tuneEn | input | 1 | Software enable for tuning |
| evalDone | input | 1 | Energy datapath has finished evaluating the candidate |
| evalLower | input | 1 | Candidate energy is below the best energy of this search |
| evalReq | output | 1 | Request to evaluate the configuration on `cacheCfg` |
| busy | output | 1 | A search is in progress |
| cacheCfg | output | 7 | Configuration that drives the cache |

## Verification
The greedy search is driven by an energy model in the bench, in three forms:
- An energy that always falls. The controller must climb every field to its ceiling, which tests the limits and the full eight-request ordering.
- An energy that never falls. Each parameter must give up after one trial, and associativity must not be tried at all at 2 KB.
- A family of pseudo-random energy landscapes. Searches chain from one final configuration to the next, which separates correct accept, revert and next-parameter decisions from off-by-one stepping and from wrong restart points.

Further directed cases cover disabling mid-search, a stray done strobe while idle, and an enable held high after a search completes.

// File: rtl/cache_tune_pkg.sv
package cache_tune_pkg;
  localparam int CFG_W     = 7;
  localparam int FIELD_W   = 2;
  localparam int SIZE_LSB  = 5;
  localparam int LINE_LSB  = 3;
  localparam int ASSOC_LSB = 1;
  localparam int WAY_LSB   = 0;
  localparam logic [FIELD_W-1:0] TOP_CODE = 2'd2;
  localparam logic [FIELD_W-1:0] WAY_TOP  = 2'd1;

  typedef enum logic [1:0] {PAR_SIZE, PAR_LINE, PAR_ASSOC, PAR_WAY} paramSel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_STEP, ST_WAIT} tuneState_e;

  typedef struct packed {
    logic      stepUp;
    logic      accept;
    logic      revert;
    paramSel_e param;
  } tuneStrobe_t;
endpackage

// File: rtl/cache_tune_datapath.sv
module cache_tune_datapath
  import cache_tune_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tuneStrobe_t      strb,
  output logic             canStep,
  output logic [CFG_W-1:0] cfgOut
);
  logic [CFG_W-1:0]   cfgReg, bestReg, stepped;
  logic [FIELD_W-1:0] curField, limit, nextField;

  // field under tuning and its ceiling, taken from the best configuration
  always_comb begin
    unique case (strb.param)
      PAR_SIZE:  begin curField = bestReg[SIZE_LSB +: FIELD_W];  limit = TOP_CODE; end
      PAR_LINE:  begin curField = bestReg[LINE_LSB +: FIELD_W];  limit = TOP_CODE; end
      PAR_ASSOC: begin curField = bestReg[ASSOC_LSB +: FIELD_W]; limit = bestReg[SIZE_LSB +: FIELD_W]; end
      default:   begin curField = {1'b0, bestReg[WAY_LSB]};      limit = WAY_TOP; end
    endcase
  end

  assign canStep   = curField < limit;
  assign nextField = curField + 2'd1;

  always_comb begin
    stepped = bestReg;
    unique case (strb.param)
      PAR_SIZE:  stepped[SIZE_LSB +: FIELD_W]  = nextField;
      PAR_LINE:  stepped[LINE_LSB +: FIELD_W]  = nextField;
      PAR_ASSOC: stepped[ASSOC_LSB +: FIELD_W] = nextField;
      default:   stepped[WAY_LSB]              = nextField[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      bestReg <= '0;
    end else begin
      if (strb.stepUp)      cfgReg <= stepped;
      else if (strb.revert) cfgReg <= bestReg;
      if (strb.accept)      bestReg <= cfgReg;
    end
  end

  assign cfgOut = cfgReg;

  // R6: associativity never exceeds what the size allows
  p_assoc_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgReg[ASSOC_LSB +: FIELD_W] <= cfgReg[SIZE_LSB +: FIELD_W]);

  // R2: reserved code never appears
  p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgReg[SIZE_LSB +: FIELD_W] != 2'b11 && cfgReg[LINE_LSB +: FIELD_W] != 2'b11 &&
    cfgReg[ASSOC_LSB +: FIELD_W] != 2'b11);

  // R10: size only falls when a rejected trial is reverted
  p_size_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.revert) |-> cfgReg[SIZE_LSB +: FIELD_W] >= $past(cfgReg[SIZE_LSB +: FIELD_W]));

  // R5: an accepted candidate differs from the previous best
  p_accept_grows_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |-> cfgReg != bestReg);
endmodule

// File: rtl/cache_tune_control.sv
module cache_tune_control
  import cache_tune_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tuneEn,
  input  logic        evalDone,
  input  logic        evalLower,
  input  logic        canStep,
  output tuneStrobe_t strb,
  output logic        evalReq,
  output logic        busy
);
  tuneState_e state, nxtState;
  paramSel_e  param, nxtParam;
  logic       doneLatch, nxtDone;

  always_comb begin
    nxtState    = state;
    nxtParam    = param;
    nxtDone     = doneLatch;
    strb        = '0;
    strb.param  = param;
    unique case (state)
      ST_IDLE: begin
        if (!tuneEn) nxtDone = 1'b0;
        else if (!doneLatch) begin
          nxtState = ST_BASE;
          nxtParam = PAR_SIZE;
        end
      end
      ST_BASE: begin
        if (!tuneEn)       nxtState = ST_IDLE;
        else if (evalDone) nxtState = ST_STEP;
      end
      ST_STEP: begin
        if (!tuneEn) nxtState = ST_IDLE;
        else if (canStep) begin
          strb.stepUp = 1'b1;
          nxtState    = ST_WAIT;
        end else if (param == PAR_WAY) begin
          nxtState = ST_IDLE;
          nxtDone  = 1'b1;
        end else nxtParam = paramSel_e'(param + 2'd1);
      end
      default: begin
        if (!tuneEn) begin
          strb.revert = 1'b1;
          nxtState    = ST_IDLE;
        end else if (evalDone) begin
          if (evalLower) begin
            strb.accept = 1'b1;
            nxtState    = ST_STEP;
          end else begin
            strb.revert = 1'b1;
            if (param == PAR_WAY) begin
              nxtState = ST_IDLE;
              nxtDone  = 1'b1;
            end else begin
              nxtParam = paramSel_e'(param + 2'd1);
              nxtState = ST_STEP;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      param     <= PAR_SIZE;
      doneLatch <= 1'b0;
    end else begin
      state     <= nxtState;
      param     <= nxtParam;
      doneLatch <= nxtDone;
    end
  end

  assign evalReq = (state == ST_BASE) || (state == ST_WAIT);
  assign busy    = state != ST_IDLE;

  // R8: dropping the enable ends the search on the next cycle
  p_disable_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && !tuneEn |=> !busy);

  // R7: a finished search does not restart while the enable is held
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy && doneLatch && tuneEn |=> !busy);

  // R9: a done strobe without a request causes no decision
  p_stray_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    !evalReq |-> !strb.accept);

  // R4: at most one strobe per cycle
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.stepUp, strb.accept, strb.revert}) <= 1);
endmodule

// File: rtl/cache_tune_ctrl.sv
module cache_tune_ctrl
  import cache_tune_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tuneEn,
  input  logic             evalDone,
  input  logic             evalLower,
  output logic             evalReq,
  output logic             busy,
  output logic [CFG_W-1:0] cacheCfg
);
  tuneStrobe_t strb;
  logic        canStep;

  cache_tune_control u_control (
    .clk(clk), .rstN(rstN), .tuneEn(tuneEn), .evalDone(evalDone),
    .evalLower(evalLower), .canStep(canStep), .strb(strb),
    .evalReq(evalReq), .busy(busy)
  );

  cache_tune_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .canStep(canStep), .cfgOut(cacheCfg)
  );

  // R4: the candidate under evaluation does not move while it is measured
  p_cfg_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    evalReq && $past(evalReq) |-> $stable(cacheCfg));
endmodule

// File: tb/cache_tune_ctrl_test.sv
module cache_tune_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tuneEn = 1'b0;
  logic       evalDone = 1'b0;
  logic       evalLower = 1'b0;
  logic       evalReq, busy;
  logic [6:0] cacheCfg;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [6:0] expSeq [0:15];
  int         expN;
  logic [6:0] expFinal;

  always #2 clk = ~clk;

  cache_tune_ctrl uut (
    .clk(clk), .rstN(rstN), .tuneEn(tuneEn), .evalDone(evalDone),
    .evalLower(evalLower), .evalReq(evalReq), .busy(busy), .cacheCfg(cacheCfg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 1: always falls, mode 2: always rises, mode 0: seeded landscape
  function automatic int energy(input logic [6:0] c, input int mode, input int seed);
    int v = int'(c);
    if (mode == 1) return 200 - v;
    if (mode == 2) return v;
    return ((v * (2 * seed + 7)) + seed * 31) % 67 + ((v ^ seed) & 3);
  endfunction

  function automatic logic [1:0] fieldOf(input logic [6:0] c, input int p);
    case (p)
      0: return c[6:5];
      1: return c[4:3];
      2: return c[2:1];
      default: return {1'b0, c[0]};
    endcase
  endfunction

  function automatic logic [6:0] withField(input logic [6:0] c, input int p, input logic [1:0] f);
    logic [6:0] r = c;
    case (p)
      0: r[6:5] = f;
      1: r[4:3] = f;
      2: r[2:1] = f;
      default: r[0] = f[0];
    endcase
    return r;
  endfunction

  task automatic buildExp(input logic [6:0] start, input int mode, input int seed);
    logic [6:0] cur = start;
    int bestE = energy(start, mode, seed);
    expN = 0;
    expSeq[expN] = cur; expN++;
    for (int p = 0; p < 4; p++) begin
      bit go = 1;
      while (go) begin
        logic [1:0] lim = (p == 2) ? cur[6:5] : (p == 3) ? 2'd1 : 2'd2;
        logic [1:0] f = fieldOf(cur, p);
        if (f >= lim) go = 0;
        else begin
          logic [6:0] cand = withField(cur, p, f + 2'd1);
          expSeq[expN] = cand; expN++;
          if (energy(cand, mode, seed) < bestE) begin
            bestE = energy(cand, mode, seed);
            cur = cand;
          end else go = 0;
        end
      end
    end
    expFinal = cur;
  endtask

  task automatic doReset();
    rstN = 1'b0; tuneEn = 1'b0; evalDone = 1'b0; evalLower = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cfg after reset", cacheCfg, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 evalReq after reset", evalReq, 0);
  endtask

  // bench plays the energy datapath and compares each request with the model
  task automatic runSearch(input int mode, input int seed);
    int n = 0;
    int bestE = 0;
    buildExp(cacheCfg, mode, seed);
    tuneEn = 1'b1;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      if (cyc == 0) chk("R7 busy during search", busy, 1);
      if (evalReq) begin
        if (n < expN) chk("R4 R2 R3 requested configuration", cacheCfg, expSeq[n]);
        else chk("R6 request beyond limit", n, expN - 1);
        if (n == 0) begin
          bestE = energy(cacheCfg, mode, seed);
          evalLower = 1'b1;               // R3: baseline flag must be ignored
        end else if (energy(cacheCfg, mode, seed) < bestE) begin
          bestE = energy(cacheCfg, mode, seed);
          evalLower = 1'b1;
        end else evalLower = 1'b0;
        evalDone = 1'b1;
        n++;
        @(negedge clk);
        evalDone = 1'b0; evalLower = 1'b0;
      end else if (!busy) break;
    end
    chk("R6 evaluation count", n, expN);
    chk("R5 final configuration", cacheCfg, expFinal);
    chk("R7 busy after search", busy, 0);
    tuneEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();

    // R9: stray done while idle
    evalDone = 1'b1; evalLower = 1'b1;
    @(negedge clk);
    evalDone = 1'b0; evalLower = 1'b0;
    @(negedge clk);
    chk("R9 cfg after stray done", cacheCfg, 0);
    chk("R9 busy after stray done", busy, 0);

    // always falling: climbs every field to its ceiling
    runSearch(1, 0);
    chk("R6 ceiling configuration", cacheCfg, 7'h55);

    // R7: enable held high after a completed search
    tuneEn = 1'b1;
    begin
      int reqSeen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (evalReq || busy) reqSeen++;
      end
      // first search with enable re-raised runs from the ceiling: baseline only
      chk("R7 R10 restart from ceiling activity", reqSeen > 0, 1);
    end
    // let that search finish, then hold the enable and watch for silence
    begin
      int active = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (i >= 10 && (evalReq || busy)) active++;
        if (evalReq) begin evalDone = 1'b1; @(negedge clk); evalDone = 1'b0; end
      end
      chk("R7 no restart while enable held", active, 0);
    end
    chk("R10 cfg kept at ceiling", cacheCfg, 7'h55);
    tuneEn = 1'b0;
    repeat (2) @(negedge clk);

    // never falling: one trial per parameter, no associativity trial at 2 KB
    doReset();
    runSearch(2, 0);
    chk("R6 no growth when energy rises", cacheCfg, 0);

    // R8: disable in the middle of a search
    doReset();
    tuneEn = 1'b1;
    begin
      int n = 0;
      for (int cyc = 0; cyc < 40 && n < 3; cyc++) begin
        @(negedge clk);
        if (evalReq) begin
          if (n == 2) begin
            chk("R4 second size trial", cacheCfg, 7'h40);
            tuneEn = 1'b0;
            n++;
          end else begin
            evalDone = 1'b1; evalLower = 1'b1;
            n++;
            @(negedge clk);
            evalDone = 1'b0; evalLower = 1'b0;
          end
        end
      end
    end
    @(negedge clk);
    chk("R8 cfg after disable", cacheCfg, 7'h20);
    chk("R8 busy after disable", busy, 0);
    chk("R8 evalReq after disable", evalReq, 0);

    // seeded landscapes, searches chained from the previous result
    for (int s = 0; s < 120; s++) begin
      if (s % 4 == 0) doReset();
      runSearch(0, s);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule